// File: doc/BRIEF.md
# Nibble-Carry Arithmetic and Logic Unit

This block computes the data result of the arithmetic, bitwise, shift, rotate and byte-exchange instructions of a 16-bit processor. The result path is purely combinational. It takes a 6-bit operation code, the destination operand, a second operand (a register value or a constant, chosen upstream), and the processor's current carry flag. Alongside the result it produces seven candidate flag values and a write-enable mask that says which of them the operation may change.

The arithmetic group reports carries at every nibble boundary of the adder, not only at the top bit. A surrounding datapath can use these for decimal adjustment or for building wider arithmetic in 4-bit steps. Subtraction reports borrows at the same positions. The shifts move data through the carry flag. The rotates and the byte exchange leave every flag alone. A codes that is not an ALU operation passes the destination operand through, and the mask is all zero.

The block also keeps a registered copy of the flags. On each clock edge this copy takes the enabled candidate values and holds the rest. A synchronous, active-high reset clears it.

Top module: `alu16_nib`

## Requirements
- R1: Code 6'b010001 (add) gives result = rd_val + src_val modulo 2^16. The carry_in input is not used, and all seven flag write-enables are set.
- R2: Code 6'b010010 (increment) gives rd_val + 1, and code 6'b010100 (decrement) gives rd_val - 1, both modulo 2^16. Both ignore src_val and set all seven write-enables.
- R3: Code 6'b010011 (subtract) gives rd_val - src_val modulo 2^16. C is set when src_val is greater than rd_val as unsigned numbers (a borrow). All seven write-enables are set.
- R4: For the arithmetic codes, QC, HC and TC are the carries out of bits 3, 7 and 11: set when the sum of the low 4, 8 or 12 bits overflows that width. For subtract and decrement they are the borrows: set when the subtrahend's low 4, 8 or 12 bits exceed the minuend's.
- R5: Flag bit order in flag_new, flag_we and flags_q is C=0, QC=1, HC=2, TC=3, Z=4, N=5, O=6. For the arithmetic codes, N is result bit 15, Z is set when the result is zero, and O is signed two's-complement overflow.
- R6: Codes 6'b010101, 6'b010110, 6'b010111 and 6'b011000 give AND, OR, XOR of the operands and NOT of rd_val. Only the Z write-enable is set, and Z is set when the result is zero.
- R7: Code 6'b011001 gives {rd_val[14:0], carry_in} with new C = rd_val[15]. Code 6'b011010 gives {carry_in, rd_val[15:1]} with new C = rd_val[0]. Only the C and Z write-enables are set.
- R8: Code 6'b011011 rotates rd_val left by one and 6'b011100 rotates it right by one. The bit shifted out enters at the other end, carry_in is not used, and no write-enable is set.
- R9: Code 6'b011101 exchanges the high and low bytes of rd_val, and no write-enable is set.
- R10: Any other code gives result = rd_val, and no write-enable is set.
- R11: On each rising clock edge, every flags_q bit whose write-enable is set takes its flag_new value, and every other bit holds. Synchronous rst clears flags_q to zero and takes priority over a write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the flag register |
| rst | input | 1 | Synchronous active-high reset of the flag register |
| op | input | 6 | Operation code |
| rd_val | input | 16 | Destination operand |
| src_val | input | 16 | Second operand (register or constant) |
| carry_in | input | 1 | Current carry flag |
| result | output | 16 | Combinational result |
| flag_new | output | 7 | Candidate flag values |
| flag_we | output | 7 | Per-flag write-enable mask |
| flags_q | output | 7 | Registered flags |

## Verification
In a single cycle, the combinational result of a new operation appears while the flag register commits the masked flags of the operation before it. A flag-changing operation followed at once by an operation with a narrower mask shows whether the bits outside that mask hold. The bench runs its vector table back to back so every adjacent pair does this. It tracks a flag model merged under the expected mask and compares it with flags_q after each edge. A reset applied in the same cycle as a full-mask add checks that clearing wins over writing.

// File: rtl/alu16_pkg.sv
package alu16_pkg;

    localparam logic [5:0] OP_ADD = 6'b010001;
    localparam logic [5:0] OP_INC = 6'b010010;
    localparam logic [5:0] OP_SUB = 6'b010011;
    localparam logic [5:0] OP_DEC = 6'b010100;
    localparam logic [5:0] OP_AND = 6'b010101;
    localparam logic [5:0] OP_OR  = 6'b010110;
    localparam logic [5:0] OP_XOR = 6'b010111;
    localparam logic [5:0] OP_NOT = 6'b011000;
    localparam logic [5:0] OP_SHL = 6'b011001;
    localparam logic [5:0] OP_SHR = 6'b011010;
    localparam logic [5:0] OP_ROL = 6'b011011;
    localparam logic [5:0] OP_ROR = 6'b011100;
    localparam logic [5:0] OP_SWP = 6'b011101;

    // Packed with C in bit 0 up to O in bit 6.
    typedef struct packed {
        logic o;
        logic n;
        logic z;
        logic tc;
        logic hc;
        logic qc;
        logic c;
    } flags_t;

    typedef enum logic [2:0] {
        GRP_ARITH,
        GRP_LOGIC,
        GRP_SHIFT,
        GRP_MOVE,
        GRP_NONE
    } op_grp_e;

    localparam flags_t WE_ARITH = 7'b1111111;
    localparam flags_t WE_LOGIC = 7'b0010000;
    localparam flags_t WE_SHIFT = 7'b0010001;
    localparam flags_t WE_NONE  = 7'b0000000;

    function automatic op_grp_e op_group(input logic [5:0] op);
        op_grp_e g;
        case (op)
            OP_ADD, OP_INC, OP_SUB, OP_DEC: g = GRP_ARITH;
            OP_AND, OP_OR, OP_XOR, OP_NOT:  g = GRP_LOGIC;
            OP_SHL, OP_SHR:                 g = GRP_SHIFT;
            OP_ROL, OP_ROR, OP_SWP:         g = GRP_MOVE;
            default:                        g = GRP_NONE;
        endcase
        return g;
    endfunction

    function automatic logic op_subtracts(input logic [5:0] op);
        return (op == OP_SUB) || (op == OP_DEC);
    endfunction

    function automatic logic op_unit_step(input logic [5:0] op);
        return (op == OP_INC) || (op == OP_DEC);
    endfunction

endpackage

// File: rtl/alu16_addsub.sv
module alu16_addsub #(
    parameter int W   = 16,
    parameter int NIB = 4
) (
    input  logic [W-1:0]     a,
    input  logic [W-1:0]     b,
    input  logic             sub,
    output logic [W-1:0]     sum,
    output logic [W/NIB-1:0] lane_cy,
    output logic             ovf
);
    localparam int LANES = W / NIB;

    logic [W-1:0]   b_eff;
    logic [LANES:0] chain;

    assign b_eff    = sub ? ~b : b;
    assign chain[0] = sub;

    // Nibble-wide adder slices: each slice's carry feeds the next.
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign {chain[i+1], sum[i*NIB +: NIB]} =
            {1'b0, a[i*NIB +: NIB]} + {1'b0, b_eff[i*NIB +: NIB]} +
            {{NIB{1'b0}}, chain[i]};
    end

    // Subtraction reports borrow, the inverse of the raw carry.
    assign lane_cy = chain[LANES:1] ^ {LANES{sub}};
    assign ovf     = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);

endmodule

// File: rtl/alu16_bitops.sv
module alu16_bitops
    import alu16_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [5:0]   op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] res,
    output logic         cout
);
    localparam int HALF = W / 2;

    always_comb begin
        res  = a;
        cout = 1'b0;
        case (op)
            OP_AND: res = a & b;
            OP_OR:  res = a | b;
            OP_XOR: res = a ^ b;
            OP_NOT: res = ~a;
            OP_SHL: begin
                res  = {a[W-2:0], cin};
                cout = a[W-1];
            end
            OP_SHR: begin
                res  = {cin, a[W-1:1]};
                cout = a[0];
            end
            OP_ROL: res = {a[W-2:0], a[W-1]};
            OP_ROR: res = {a[0], a[W-1:1]};
            OP_SWP: res = {a[HALF-1:0], a[W-1:HALF]};
            default: res = a;
        endcase
    end

endmodule

// File: rtl/alu16_flagreg.sv
module alu16_flagreg
    import alu16_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  flags_t fl_new,
    input  flags_t fl_we,
    output flags_t fl_q
);
    always_ff @(posedge clk) begin
        if (rst) fl_q <= '0;
        else     fl_q <= (fl_q & ~fl_we) | (fl_new & fl_we);
    end

    // R11: with no enable, the register keeps its value.
    p_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (fl_we == '0) |=> $stable(fl_q));

    // R11: enabled bits take the candidate values of the previous cycle.
    p_write_r11: assert property (@(posedge clk) disable iff (rst)
        (fl_we != '0) |=> ((fl_q & $past(fl_we)) == ($past(fl_new) & $past(fl_we))));

    // R11: reset clears the register.
    p_reset_r11: assert property (@(posedge clk)
        rst |=> (fl_q == '0));

endmodule

// File: rtl/alu16_nib.sv
module alu16_nib
    import alu16_pkg::*;
#(
    parameter int W   = 16,
    parameter int NIB = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [5:0]   op,
    input  logic [W-1:0] rd_val,
    input  logic [W-1:0] src_val,
    input  logic         carry_in,
    output logic [W-1:0] result,
    output logic [6:0]   flag_new,
    output logic [6:0]   flag_we,
    output logic [6:0]   flags_q
);
    localparam int LANES = W / NIB;

    op_grp_e        grp;
    logic [W-1:0]   addend;
    logic [W-1:0]   as_sum;
    logic [LANES-1:0] as_cy;
    logic           as_ovf;
    logic [W-1:0]   bo_res;
    logic           bo_cout;
    flags_t         fn;
    flags_t         we;
    flags_t         fq;

    assign grp    = op_group(op);
    assign addend = op_unit_step(op) ? W'(1) : src_val;

    alu16_addsub #(.W(W), .NIB(NIB)) u_addsub (
        .a       (rd_val),
        .b       (addend),
        .sub     (op_subtracts(op)),
        .sum     (as_sum),
        .lane_cy (as_cy),
        .ovf     (as_ovf)
    );

    alu16_bitops #(.W(W)) u_bitops (
        .op   (op),
        .a    (rd_val),
        .b    (src_val),
        .cin  (carry_in),
        .res  (bo_res),
        .cout (bo_cout)
    );

    always_comb begin
        result = rd_val;
        fn     = '0;
        we     = WE_NONE;
        case (grp)
            GRP_ARITH: begin
                result = as_sum;
                fn.c   = as_cy[LANES-1];
                fn.qc  = as_cy[0];
                fn.hc  = as_cy[1];
                fn.tc  = as_cy[2];
                fn.z   = (as_sum == '0);
                fn.n   = as_sum[W-1];
                fn.o   = as_ovf;
                we     = WE_ARITH;
            end
            GRP_LOGIC: begin
                result = bo_res;
                fn.z   = (bo_res == '0);
                we     = WE_LOGIC;
            end
            GRP_SHIFT: begin
                result = bo_res;
                fn.c   = bo_cout;
                fn.z   = (bo_res == '0);
                we     = WE_SHIFT;
            end
            GRP_MOVE: result = bo_res;
            default:  result = rd_val;
        endcase
    end

    alu16_flagreg u_flagreg (
        .clk    (clk),
        .rst    (rst),
        .fl_new (fn),
        .fl_we  (we),
        .fl_q   (fq)
    );

    assign flag_new = fn;
    assign flag_we  = we;
    assign flags_q  = fq;

    // R10: codes outside the table pass the operand, no enables.
    p_unknown_pass_r10: assert property (@(posedge clk) disable iff (rst)
        (op_group(op) == GRP_NONE) |-> (result == rd_val && flag_we == 7'b0));

    // R6: bitwise group may only touch Z.
    p_logic_mask_r6: assert property (@(posedge clk) disable iff (rst)
        (op >= OP_AND && op <= OP_NOT) |-> (flag_we == 7'b0010000));

    // R8: rotates change no flags.
    p_rot_noflag_r8: assert property (@(posedge clk) disable iff (rst)
        (op == OP_ROL || op == OP_ROR) |-> (flag_we == 7'b0));

    // R9: byte exchange changes no flags and keeps the bit population.
    p_swap_noflag_r9: assert property (@(posedge clk) disable iff (rst)
        (op == OP_SWP) |-> (flag_we == 7'b0 && $countones(result) == $countones(rd_val)));

    // R5: an enabled Z agrees with the result value.
    p_zero_flag_r5: assert property (@(posedge clk) disable iff (rst)
        flag_we[4] |-> (flag_new[4] == (result == '0)));

    // R5: N follows the result sign for arithmetic.
    p_neg_flag_r5: assert property (@(posedge clk) disable iff (rst)
        (op >= OP_ADD && op <= OP_DEC) |-> (flag_new[5] == result[W-1]));

    // R7: left shift takes carry in at bit 0 and sends bit 15 out.
    p_shl_carry_r7: assert property (@(posedge clk) disable iff (rst)
        (op == OP_SHL) |-> (result[0] == carry_in && flag_new[0] == rd_val[W-1]));

    // R1: add enables every flag.
    p_add_mask_r1: assert property (@(posedge clk) disable iff (rst)
        (op == OP_ADD) |-> (flag_we == 7'b1111111));

endmodule

// File: tb/alu16_nib_tb.sv
module alu16_nib_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 32;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  op = '0;
    logic [15:0] rd_val = '0;
    logic [15:0] src_val = '0;
    logic        carry_in = 1'b0;
    logic [15:0] result;
    logic [6:0]  flag_new;
    logic [6:0]  flag_we;
    logic [6:0]  flags_q;

    int checks = 0;
    int errors = 0;
    logic [6:0] model_q = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    alu16_nib u_dut (
        .clk(clk), .rst(rst), .op(op), .rd_val(rd_val), .src_val(src_val),
        .carry_in(carry_in), .result(result), .flag_new(flag_new),
        .flag_we(flag_we), .flags_q(flags_q)
    );

    // {op, rd, src, carry_in, expected result}
    localparam logic [54:0] VECS [0:NVEC-1] = '{
        {6'h11, 16'h0001, 16'h0002, 1'b0, 16'h0003},
        {6'h11, 16'hFFFF, 16'h0001, 1'b0, 16'h0000},
        {6'h11, 16'h7FFF, 16'h0001, 1'b0, 16'h8000},
        {6'h11, 16'h0008, 16'h0008, 1'b0, 16'h0010},
        {6'h11, 16'h1234, 16'h0000, 1'b1, 16'h1234},
        {6'h13, 16'h0010, 16'h0001, 1'b0, 16'h000F},
        {6'h13, 16'h0000, 16'h0001, 1'b0, 16'hFFFF},
        {6'h13, 16'h8000, 16'h0001, 1'b0, 16'h7FFF},
        {6'h13, 16'h1234, 16'h1234, 1'b1, 16'h0000},
        {6'h12, 16'h00FF, 16'h5555, 1'b0, 16'h0100},
        {6'h14, 16'h0100, 16'h5555, 1'b1, 16'h00FF},
        {6'h12, 16'hFFFF, 16'h0000, 1'b0, 16'h0000},
        {6'h14, 16'h0000, 16'h0000, 1'b0, 16'hFFFF},
        {6'h15, 16'hF0F0, 16'h0FF0, 1'b0, 16'h00F0},
        {6'h15, 16'hF0F0, 16'h0F0F, 1'b0, 16'h0000},
        {6'h16, 16'h1200, 16'h0034, 1'b0, 16'h1234},
        {6'h17, 16'hAAAA, 16'hAAAA, 1'b1, 16'h0000},
        {6'h18, 16'hFFFF, 16'h1234, 1'b0, 16'h0000},
        {6'h18, 16'h1234, 16'h0000, 1'b0, 16'hEDCB},
        {6'h19, 16'h8001, 16'h0000, 1'b0, 16'h0002},
        {6'h19, 16'h4000, 16'h0000, 1'b1, 16'h8001},
        {6'h19, 16'h8000, 16'h0000, 1'b0, 16'h0000},
        {6'h1A, 16'h0001, 16'h0000, 1'b0, 16'h0000},
        {6'h1A, 16'h0002, 16'h0000, 1'b1, 16'h8001},
        {6'h1B, 16'h8001, 16'h0000, 1'b0, 16'h0003},
        {6'h1C, 16'h0001, 16'h0000, 1'b0, 16'h8000},
        {6'h1B, 16'h0000, 16'h0000, 1'b1, 16'h0000},
        {6'h1D, 16'h12AB, 16'h0000, 1'b0, 16'hAB12},
        {6'h00, 16'hBEEF, 16'h1111, 1'b1, 16'hBEEF},
        {6'h3F, 16'h0000, 16'hFFFF, 1'b0, 16'h0000},
        {6'h1E, 16'h5A5A, 16'h0001, 1'b1, 16'h5A5A},
        {6'h10, 16'h1111, 16'h2222, 1'b0, 16'h1111}
    };

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic string res_req(input logic [5:0] o);
        case (o)
            6'h11: return "R1";
            6'h12, 6'h14: return "R2";
            6'h13: return "R3";
            6'h15, 6'h16, 6'h17, 6'h18: return "R6";
            6'h19, 6'h1A: return "R7";
            6'h1B, 6'h1C: return "R8";
            6'h1D: return "R9";
            default: return "R10";
        endcase
    endfunction

    function automatic string flag_req(input logic [5:0] o);
        if (o >= 6'h11 && o <= 6'h14) return "R4 R5";
        return res_req(o);
    endfunction

    // Returns {we[6:0], flags[6:0]}; flag order C,QC,HC,TC,Z,N,O from bit 0.
    function automatic logic [13:0] ref_flags(input logic [5:0] o,
            input logic [15:0] a, input logic [15:0] b, input logic cin);
        int unsigned ua = a;
        int unsigned ub = b;
        int unsigned r;
        logic [6:0] f = '0;
        logic [6:0] w = '0;
        logic [15:0] rs;
        if (o == 6'h12 || o == 6'h14) ub = 1;
        case (o)
            6'h11, 6'h12: begin
                r = (ua + ub) & 32'hFFFF;
                rs = r[15:0];
                f[0] = (ua + ub) > 32'hFFFF;
                f[1] = ((ua & 32'hF) + (ub & 32'hF)) > 32'hF;
                f[2] = ((ua & 32'hFF) + (ub & 32'hFF)) > 32'hFF;
                f[3] = ((ua & 32'hFFF) + (ub & 32'hFFF)) > 32'hFFF;
                f[6] = (ua[15] == ub[15]) && (rs[15] != ua[15]);
                f[4] = (rs == 0); f[5] = rs[15]; w = 7'h7F;
            end
            6'h13, 6'h14: begin
                r = (ua - ub) & 32'hFFFF;
                rs = r[15:0];
                f[0] = ua < ub;
                f[1] = (ua & 32'hF) < (ub & 32'hF);
                f[2] = (ua & 32'hFF) < (ub & 32'hFF);
                f[3] = (ua & 32'hFFF) < (ub & 32'hFFF);
                f[6] = (ua[15] != ub[15]) && (rs[15] != ua[15]);
                f[4] = (rs == 0); f[5] = rs[15]; w = 7'h7F;
            end
            6'h15: begin f[4] = ((ua & ub) == 0); w = 7'h10; end
            6'h16: begin f[4] = ((ua | ub) == 0); w = 7'h10; end
            6'h17: begin f[4] = ((ua ^ ub) == 0); w = 7'h10; end
            6'h18: begin f[4] = (ua == 32'hFFFF); w = 7'h10; end
            6'h19: begin
                r = ((ua * 2) & 32'hFFFF) | (cin ? 1 : 0);
                f[0] = ua >= 32'h8000; f[4] = (r == 0); w = 7'h11;
            end
            6'h1A: begin
                r = (ua / 2) | (cin ? 32'h8000 : 0);
                f[0] = (ua % 2) == 1; f[4] = (r == 0); w = 7'h11;
            end
            default: begin f = '0; w = '0; end
        endcase
        return {w, f};
    endfunction

    initial begin : watchdog
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        logic [13:0] exp;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R11", "flags_q under reset", 32'(flags_q), 32'h0);
        rst = 1'b0;

        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            op       = VECS[i][54:49];
            rd_val   = VECS[i][48:33];
            src_val  = VECS[i][32:17];
            carry_in = VECS[i][16];
            #1;
            exp = ref_flags(op, rd_val, src_val, carry_in);
            chk(res_req(op), $sformatf("result vec %0d", i), 32'(result), 32'(VECS[i][15:0]));
            chk(res_req(op), $sformatf("flag_we vec %0d", i), 32'(flag_we), 32'(exp[13:7]));
            chk(flag_req(op), $sformatf("flag_new vec %0d", i),
                32'(flag_new & exp[13:7]), 32'(exp[6:0] & exp[13:7]));
            @(posedge clk);
            #1;
            model_q = (model_q & ~exp[13:7]) | (exp[6:0] & exp[13:7]);
            chk("R11", $sformatf("flags_q after vec %0d", i), 32'(flags_q), 32'(model_q));
        end

        // R11: reset in the same cycle as a full-mask add clears the flags.
        @(negedge clk);
        op = 6'h11; rd_val = 16'hFFFF; src_val = 16'h0001; carry_in = 1'b0;
        rst = 1'b1;
        @(posedge clk);
        #1;
        chk("R11", "reset beats write", 32'(flags_q), 32'h0);

        // R11: the add takes effect once reset is released.
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #1;
        chk("R11", "write after reset", 32'(flags_q), 32'h1F);

        // R8: a held rotate leaves the flags as they were over several edges.
        @(negedge clk);
        op = 6'h1C; rd_val = 16'h0000; carry_in = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        chk("R8", "flags hold across rotates", 32'(flags_q), 32'h1F);
        chk("R8", "ror of zero with carry set", 32'(result), 32'h0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule